// File: doc/BRIEF.md
# Address-Striped Request/Response Crossbar

This block joins three requesting clients to three serving managers inside a shared-memory fabric. The managers are two memory banks and one I/O device. Each client request is steered by its address. Inside the memory window, consecutive 16-byte stripes alternate between the two banks to spread the load. A small fixed range goes to the I/O device. Any other address is answered by the crossbar itself with an error response and is never forwarded.

Every manager port has a round-robin arbiter that picks among the clients contending for it. The crossbar stamps each forwarded request with the index of the client port it came from. Managers return that identifier with their response, and the return path uses it to reach the one client that asked. Each client keeps at most one request in flight, so responses never need reordering.

All four data paths (client request, manager request, manager response, client response) are valid/ready streams. A transfer completes on a rising clock edge where valid and ready are both high. A source that raises valid keeps it high, with its payload unchanged, until ready is seen. A sink may hold ready low for any number of cycles. The request and response paths add no register stage. The only exception is the error response, which appears one cycle after the unmapped request is accepted.

Top module: `stripe_xbar`

## Requirements
- R1: A request whose address lies in the memory window (default 0x800 to 0x8FF) goes to manager 0 when address bit 4 is 0 and to manager 1 when address bit 4 is 1. For example, 0x800–0x80F and 0x820–0x82F go to manager 0, and 0x810–0x81F and 0x8F0–0x8FF go to manager 1.
- R2: A request whose address lies in 0x100 to 0x10F goes to manager 2, the I/O device.
- R3: A forwarded request carries the client's address, write data and write flag unchanged. Its ID field equals the client port index (0, 1 or 2).
- R4: A request to any other address (for example 0x0FF, 0x110, 0x7FF or 0x900) raises no manager valid. It is accepted while that client has no error response pending. On the next cycle the same client sees a response with the error flag set to 1 and read data 0. No other client sees it.
- R5: When several clients contend for one manager, the grant goes round-robin. Searching starts at the port just above the last one served, wrapping around, and client 0 is searched first after reset.
- R6: While a manager's request valid is high and its ready is low, the granted client, and with it the manager-side payload and ID, stays the same.
- R7: A manager response is presented only to the client whose index equals the response ID. The manager's response ready follows that client's response ready.
- R8: A pending error response keeps its valid high and its flag set until the client raises response ready. While it is pending, a new unmapped request from that client is not accepted.
- R9: Requests from different clients to different managers are all forwarded in the same cycle.
- R10: During and right after reset, no client response valid and no manager request valid is high while the inputs are idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| cli_req_valid | input | 3 | Request valid, one bit per client |
| cli_req_ready | output | 3 | Request accepted, one bit per client |
| cli_req_addr | input | 3*AW | Request addresses, client c at bits [c*AW +: AW] |
| cli_req_wdata | input | 3*DW | Write data per client |
| cli_req_write | input | 3 | 1 = write, 0 = read, per client |
| cli_rsp_valid | output | 3 | Response valid per client |
| cli_rsp_ready | input | 3 | Client can take its response |
| cli_rsp_rdata | output | 3*DW | Response data per client |
| cli_rsp_err | output | 3 | 1 = decode-error response |
| mgr_req_valid | output | 3 | Request valid per manager (0: bank A, 1: bank B, 2: I/O) |
| mgr_req_ready | input | 3 | Manager takes the request |
| mgr_req_addr | output | 3*AW | Forwarded address per manager |
| mgr_req_wdata | output | 3*DW | Forwarded write data per manager |
| mgr_req_write | output | 3 | Forwarded write flag per manager |
| mgr_req_id | output | 6 | Requesting client index per manager, 2 bits each |
| mgr_rsp_valid | input | 3 | Response valid per manager |
| mgr_rsp_ready | output | 3 | Response taken by the addressed client |
| mgr_rsp_rdata | input | 3*DW | Response data per manager |
| mgr_rsp_id | input | 6 | Client index the response belongs to, 2 bits each |

## Verification
A manager's response to one client can leave the crossbar in the same cycle as the error response the crossbar itself generates for a different client. The bench provokes this by sending an unmapped address from client 2. In the following cycle it has bank A return a response tagged ID 0. Both clients must then see valid at once, each with its own data and error flag, and bank A's ready must follow client 0 alone. In another scenario, arbitration and parallel forwarding coincide. All three clients request bank A while bank A holds ready low. The bench checks that the grant stays frozen and then rotates 0, 1, 2, 0, and it separately checks that requests to three different managers all pass in one cycle.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  localparam int NUM_CLI = 3;
  localparam int NUM_MGR = 3;
  localparam int IDW     = 2;

  typedef enum logic [1:0] {
    TGT_BANK0 = 2'd0,
    TGT_BANK1 = 2'd1,
    TGT_IO    = 2'd2,
    TGT_NONE  = 2'd3
  } tgt_e;
endpackage

// File: rtl/xbar_addr_dec.sv
module xbar_addr_dec
  import xbar_pkg::*;
#(
  parameter int unsigned AW         = 12,
  parameter int unsigned MEM_BASE   = 'h800,
  parameter int unsigned MEM_SIZE   = 'h100,
  parameter int unsigned IO_BASE    = 'h100,
  parameter int unsigned IO_SIZE    = 'h10,
  parameter int unsigned STRIPE_BIT = 4
) (
  input  logic [AW-1:0] addr,
  output tgt_e          tgt
);
  localparam logic [AW:0] MEM_LO = (AW+1)'(MEM_BASE);
  localparam logic [AW:0] MEM_HI = (AW+1)'(MEM_BASE + MEM_SIZE);
  localparam logic [AW:0] IO_LO  = (AW+1)'(IO_BASE);
  localparam logic [AW:0] IO_HI  = (AW+1)'(IO_BASE + IO_SIZE);

  logic [AW:0] a_ext;
  logic        in_mem, in_io;

  always_comb begin
    a_ext  = {1'b0, addr};
    in_mem = (a_ext >= MEM_LO) && (a_ext < MEM_HI);
    in_io  = (a_ext >= IO_LO) && (a_ext < IO_HI);
    if (in_mem)     tgt = addr[STRIPE_BIT] ? TGT_BANK1 : TGT_BANK0;
    else if (in_io) tgt = TGT_IO;
    else            tgt = TGT_NONE;
  end
endmodule

// File: rtl/xbar_rr_arb.sv
module xbar_rr_arb #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic         stall,
  input  logic         fire,
  output logic [N-1:0] gnt
);
  localparam int PW = (N > 1) ? $clog2(N) : 1;

  logic [PW-1:0] ptr;
  logic [PW-1:0] win;
  logic [N-1:0]  scan_gnt;
  logic [N-1:0]  held;
  logic          held_v;
  logic          found;

  always_comb begin
    scan_gnt = '0;
    win      = '0;
    found    = 1'b0;
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = int'(ptr) + k;
      if (idx >= N) idx = idx - N;
      if (!found && req[idx]) begin
        scan_gnt[idx] = 1'b1;
        win           = PW'(idx);
        found         = 1'b1;
      end
    end
  end

  always_comb begin
    if (held_v && |(held & req)) gnt = held;
    else                         gnt = scan_gnt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr    <= '0;
      held   <= '0;
      held_v <= 1'b0;
    end else begin
      held_v <= stall;
      held   <= gnt;
      if (fire) begin
        if (held_v && |(held & req)) begin
          for (int k = 0; k < N; k++)
            if (held[k]) ptr <= (k == N-1) ? '0 : PW'(k + 1);
        end else begin
          ptr <= (int'(win) == N-1) ? '0 : win + 1'b1;
        end
      end
    end
  end

  // R5
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  // R6
  grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (gnt == $past(gnt)));
endmodule

// File: rtl/xbar_err_rsp.sv
module xbar_err_rsp (
  input  logic clk,
  input  logic rst_n,
  input  logic miss_valid,
  output logic miss_ready,
  output logic rsp_valid,
  input  logic rsp_ready
);
  logic pend;
  logic take;

  assign miss_ready = !pend;
  assign take       = miss_valid && !pend;
  assign rsp_valid  = pend;

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= 1'b0;
    else        pend <= take || (pend && !rsp_ready);
  end

  // R4
  err_next_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> rsp_valid);

  // R8
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid);
endmodule

// File: rtl/xbar_rsp_sel.sv
module xbar_rsp_sel #(
  parameter int NM  = 3,
  parameter int IDW = 2,
  parameter int DW  = 16,
  parameter int CID = 0
) (
  input  logic [NM-1:0]     mgr_valid,
  input  logic [NM*IDW-1:0] mgr_id,
  input  logic [NM*DW-1:0]  mgr_data,
  input  logic              err_valid,
  output logic              out_valid,
  output logic [DW-1:0]     out_data,
  output logic              out_err,
  output logic [NM-1:0]     src,
  output logic              take_err
);
  always_comb begin
    src      = '0;
    take_err = err_valid;
    out_data = '0;
    if (!err_valid) begin
      for (int m = 0; m < NM; m++) begin
        if (src == '0 && mgr_valid[m] && mgr_id[m*IDW +: IDW] == IDW'(CID)) begin
          src[m]   = 1'b1;
          out_data = mgr_data[m*DW +: DW];
        end
      end
    end
    out_valid = take_err || (|src);
    out_err   = take_err;
  end
endmodule

// File: rtl/stripe_xbar.sv
module stripe_xbar
  import xbar_pkg::*;
#(
  parameter int unsigned AW         = 12,
  parameter int unsigned DW         = 16,
  parameter int unsigned MEM_BASE   = 'h800,
  parameter int unsigned MEM_SIZE   = 'h100,
  parameter int unsigned IO_BASE    = 'h100,
  parameter int unsigned IO_SIZE    = 'h10,
  parameter int unsigned STRIPE_BIT = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_CLI-1:0]     cli_req_valid,
  output logic [NUM_CLI-1:0]     cli_req_ready,
  input  logic [NUM_CLI*AW-1:0]  cli_req_addr,
  input  logic [NUM_CLI*DW-1:0]  cli_req_wdata,
  input  logic [NUM_CLI-1:0]     cli_req_write,
  output logic [NUM_CLI-1:0]     cli_rsp_valid,
  input  logic [NUM_CLI-1:0]     cli_rsp_ready,
  output logic [NUM_CLI*DW-1:0]  cli_rsp_rdata,
  output logic [NUM_CLI-1:0]     cli_rsp_err,
  output logic [NUM_MGR-1:0]     mgr_req_valid,
  input  logic [NUM_MGR-1:0]     mgr_req_ready,
  output logic [NUM_MGR*AW-1:0]  mgr_req_addr,
  output logic [NUM_MGR*DW-1:0]  mgr_req_wdata,
  output logic [NUM_MGR-1:0]     mgr_req_write,
  output logic [NUM_MGR*IDW-1:0] mgr_req_id,
  input  logic [NUM_MGR-1:0]     mgr_rsp_valid,
  output logic [NUM_MGR-1:0]     mgr_rsp_ready,
  input  logic [NUM_MGR*DW-1:0]  mgr_rsp_rdata,
  input  logic [NUM_MGR*IDW-1:0] mgr_rsp_id
);
  localparam int NC = NUM_CLI;
  localparam int NM = NUM_MGR;
  localparam logic [AW:0] MEM_LO = (AW+1)'(MEM_BASE);
  localparam logic [AW:0] MEM_HI = (AW+1)'(MEM_BASE + MEM_SIZE);
  localparam logic [AW:0] IO_LO  = (AW+1)'(IO_BASE);
  localparam logic [AW:0] IO_HI  = (AW+1)'(IO_BASE + IO_SIZE);

  tgt_e                  dec_tgt [NC];
  logic [NC-1:0]         miss;
  logic [NC-1:0]         err_rdy;
  logic [NC-1:0]         err_pend;
  logic [NC-1:0]         err_take;
  logic [NM-1:0][NC-1:0] arb_req;
  logic [NM-1:0][NC-1:0] gnt;
  logic [NC-1:0][NM-1:0] rsp_src;

  // Request side: decode and error responder per client
  for (genvar c = 0; c < NC; c++) begin : g_cli
    xbar_addr_dec #(
      .AW(AW), .MEM_BASE(MEM_BASE), .MEM_SIZE(MEM_SIZE),
      .IO_BASE(IO_BASE), .IO_SIZE(IO_SIZE), .STRIPE_BIT(STRIPE_BIT)
    ) u_dec (
      .addr (cli_req_addr[c*AW +: AW]),
      .tgt  (dec_tgt[c])
    );

    assign miss[c] = (dec_tgt[c] == TGT_NONE);

    xbar_err_rsp u_err (
      .clk        (clk),
      .rst_n      (rst_n),
      .miss_valid (cli_req_valid[c] && miss[c]),
      .miss_ready (err_rdy[c]),
      .rsp_valid  (err_pend[c]),
      .rsp_ready  (cli_rsp_ready[c] && err_take[c])
    );

    xbar_rsp_sel #(.NM(NM), .IDW(IDW), .DW(DW), .CID(c)) u_rsel (
      .mgr_valid (mgr_rsp_valid),
      .mgr_id    (mgr_rsp_id),
      .mgr_data  (mgr_rsp_rdata),
      .err_valid (err_pend[c]),
      .out_valid (cli_rsp_valid[c]),
      .out_data  (cli_rsp_rdata[c*DW +: DW]),
      .out_err   (cli_rsp_err[c]),
      .src       (rsp_src[c]),
      .take_err  (err_take[c])
    );
  end

  // Per-manager arbitration
  for (genvar m = 0; m < NM; m++) begin : g_mgr
    always_comb begin
      for (int c = 0; c < NC; c++)
        arb_req[m][c] = cli_req_valid[c] && (int'(dec_tgt[c]) == m);
    end

    xbar_rr_arb #(.N(NC)) u_arb (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (arb_req[m]),
      .stall (mgr_req_valid[m] && !mgr_req_ready[m]),
      .fire  (mgr_req_valid[m] && mgr_req_ready[m]),
      .gnt   (gnt[m])
    );

    always_comb begin
      mgr_req_valid[m]            = |gnt[m];
      mgr_req_addr[m*AW +: AW]    = '0;
      mgr_req_wdata[m*DW +: DW]   = '0;
      mgr_req_write[m]            = 1'b0;
      mgr_req_id[m*IDW +: IDW]    = '0;
      for (int c = 0; c < NC; c++) begin
        if (gnt[m][c]) begin
          mgr_req_addr[m*AW +: AW]  = cli_req_addr[c*AW +: AW];
          mgr_req_wdata[m*DW +: DW] = cli_req_wdata[c*DW +: DW];
          mgr_req_write[m]          = cli_req_write[c];
          mgr_req_id[m*IDW +: IDW]  = IDW'(c);
        end
      end
    end
  end

  // Client request ready
  always_comb begin
    for (int c = 0; c < NC; c++) begin
      cli_req_ready[c] = 1'b0;
      if (miss[c]) cli_req_ready[c] = err_rdy[c];
      else begin
        for (int m = 0; m < NM; m++)
          if (int'(dec_tgt[c]) == m)
            cli_req_ready[c] = mgr_req_ready[m] && gnt[m][c];
      end
    end
  end

  // Manager response ready follows the addressed client
  always_comb begin
    for (int m = 0; m < NM; m++) begin
      mgr_rsp_ready[m] = 1'b0;
      for (int c = 0; c < NC; c++)
        if (rsp_src[c][m] && cli_rsp_ready[c]) mgr_rsp_ready[m] = 1'b1;
    end
  end

  // R1
  bank0_stripe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mgr_req_valid[0] |-> ({1'b0, mgr_req_addr[0 +: AW]} >= MEM_LO &&
                          {1'b0, mgr_req_addr[0 +: AW]} < MEM_HI &&
                          !mgr_req_addr[STRIPE_BIT]));

  // R1
  bank1_stripe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mgr_req_valid[1] |-> ({1'b0, mgr_req_addr[AW +: AW]} >= MEM_LO &&
                          {1'b0, mgr_req_addr[AW +: AW]} < MEM_HI &&
                          mgr_req_addr[AW + STRIPE_BIT]));

  // R2
  io_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mgr_req_valid[2] |-> ({1'b0, mgr_req_addr[2*AW +: AW]} >= IO_LO &&
                          {1'b0, mgr_req_addr[2*AW +: AW]} < IO_HI));

  for (genvar m = 0; m < NM; m++) begin : g_rsp_chk
    // R7
    rsp_to_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mgr_rsp_valid[m] && mgr_rsp_ready[m]) |->
        (cli_rsp_valid[mgr_rsp_id[m*IDW +: IDW]] &&
         cli_rsp_ready[mgr_rsp_id[m*IDW +: IDW]]));
  end
endmodule

// File: tb/sim_stripe_xbar.sv
module sim_stripe_xbar;
  localparam int AW = 12;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    cli_req_valid = '0;
  logic [2:0]    cli_req_ready;
  logic [3*AW-1:0] cli_req_addr = '0;
  logic [3*DW-1:0] cli_req_wdata = '0;
  logic [2:0]    cli_req_write = '0;
  logic [2:0]    cli_rsp_valid;
  logic [2:0]    cli_rsp_ready = '0;
  logic [3*DW-1:0] cli_rsp_rdata;
  logic [2:0]    cli_rsp_err;
  logic [2:0]    mgr_req_valid;
  logic [2:0]    mgr_req_ready = '0;
  logic [3*AW-1:0] mgr_req_addr;
  logic [3*DW-1:0] mgr_req_wdata;
  logic [2:0]    mgr_req_write;
  logic [5:0]    mgr_req_id;
  logic [2:0]    mgr_rsp_valid = '0;
  logic [2:0]    mgr_rsp_ready;
  logic [3*DW-1:0] mgr_rsp_rdata = '0;
  logic [5:0]    mgr_rsp_id = '0;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  stripe_xbar u0 (
    .clk, .rst_n,
    .cli_req_valid, .cli_req_ready, .cli_req_addr, .cli_req_wdata, .cli_req_write,
    .cli_rsp_valid, .cli_rsp_ready, .cli_rsp_rdata, .cli_rsp_err,
    .mgr_req_valid, .mgr_req_ready, .mgr_req_addr, .mgr_req_wdata, .mgr_req_write,
    .mgr_req_id,
    .mgr_rsp_valid, .mgr_rsp_ready, .mgr_rsp_rdata, .mgr_rsp_id
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic drive_cli(int c, logic [AW-1:0] a, logic [DW-1:0] d, logic w);
    cli_req_addr[c*AW +: AW]  = a;
    cli_req_wdata[c*DW +: DW] = d;
    cli_req_write[c]          = w;
    cli_req_valid[c]          = 1'b1;
  endtask

  task automatic t_reset;
    @(negedge clk);
    #1;
    chk("R10 rsp valid in reset", 32'(cli_rsp_valid), 0);
    chk("R10 mgr valid in reset", 32'(mgr_req_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk("R10 rsp valid after reset", 32'(cli_rsp_valid), 0);
    chk("R10 mgr valid after reset", 32'(mgr_req_valid), 0);
  endtask

  // R5 / R6: all clients contend for bank A
  task automatic t_rr;
    @(negedge clk);
    mgr_req_ready = 3'b000;
    drive_cli(0, 12'h800, 16'hA000, 1'b1);
    drive_cli(1, 12'h820, 16'hA001, 1'b0);
    drive_cli(2, 12'h840, 16'hA002, 1'b1);
    #1;
    chk("R5 first grant id", 32'(mgr_req_id[1:0]), 0);
    chk("R5 first grant addr", 32'(mgr_req_addr[0 +: AW]), 32'h800);
    @(negedge clk);
    #1;
    chk("R6 held grant id", 32'(mgr_req_id[1:0]), 0);
    chk("R6 held grant data", 32'(mgr_req_wdata[0 +: DW]), 32'hA000);
    mgr_req_ready = 3'b001;
    #0.5;
    chk("R5 ready of granted", 32'(cli_req_ready), 32'b001);
    @(negedge clk);
    #1;
    chk("R5 rotate to 1", 32'(mgr_req_id[1:0]), 1);
    chk("R5 addr of 1", 32'(mgr_req_addr[0 +: AW]), 32'h820);
    @(negedge clk);
    #1;
    chk("R5 rotate to 2", 32'(mgr_req_id[1:0]), 2);
    @(negedge clk);
    #1;
    chk("R5 wrap to 0", 32'(mgr_req_id[1:0]), 0);
    cli_req_valid = '0;
    mgr_req_ready = '0;
  endtask

  // R1 / R2 / R3 / R4 decode (no clock edge while driven)
  task automatic t_route;
    logic [AW-1:0] addrs [12] = '{12'h800, 12'h80F, 12'h810, 12'h81F, 12'h820, 12'h8FF,
                                  12'h100, 12'h10F, 12'h0FF, 12'h110, 12'h900, 12'h7FF};
    int tgts [12] = '{0, 0, 1, 1, 0, 1, 2, 2, 3, 3, 3, 3};
    for (int i = 0; i < 12; i++) begin
      int c;
      c = i % 3;
      @(negedge clk);
      mgr_req_ready = 3'b111;
      drive_cli(c, addrs[i], 16'(16'h5A00 + i), 1'(i % 2));
      #1;
      if (tgts[i] == 3) begin
        chk("R4 unmapped not forwarded", 32'(mgr_req_valid), 0);
        chk("R4 unmapped accepted", 32'(cli_req_ready[c]), 1);
      end else begin
        string r;
        r = (tgts[i] == 2) ? "R2" : "R1";
        chk({r, " manager select"}, 32'(mgr_req_valid), 32'(1 << tgts[i]));
        chk("R3 id", 32'(mgr_req_id[tgts[i]*2 +: 2]), 32'(c));
        chk("R3 addr", 32'(mgr_req_addr[tgts[i]*AW +: AW]), 32'(addrs[i]));
        chk("R3 wdata", 32'(mgr_req_wdata[tgts[i]*DW +: DW]), 32'(16'h5A00 + i));
        chk("R3 write", 32'(mgr_req_write[tgts[i]]), 32'(i % 2));
      end
      cli_req_valid = '0;
      mgr_req_ready = '0;
    end
  endtask

  // R9: three managers at once
  task automatic t_parallel;
    @(negedge clk);
    mgr_req_ready = 3'b111;
    drive_cli(0, 12'h820, 16'h1111, 1'b0);
    drive_cli(1, 12'h830, 16'h2222, 1'b1);
    drive_cli(2, 12'h105, 16'h3333, 1'b0);
    #1;
    chk("R9 all managers valid", 32'(mgr_req_valid), 32'b111);
    chk("R9 ids", 32'(mgr_req_id), 32'b10_01_00);
    chk("R9 all clients ready", 32'(cli_req_ready), 32'b111);
    cli_req_valid = '0;
    mgr_req_ready = '0;
  endtask

  // R7: response routing by ID
  task automatic t_rsp_route;
    @(negedge clk);
    mgr_rsp_valid = 3'b010;
    mgr_rsp_id    = 6'b00_10_00;
    mgr_rsp_rdata[DW +: DW] = 16'hBEEF;
    cli_rsp_ready = 3'b011;
    #1;
    chk("R7 only owner valid", 32'(cli_rsp_valid), 32'b100);
    chk("R7 owner data", 32'(cli_rsp_rdata[2*DW +: DW]), 32'hBEEF);
    chk("R7 owner not err", 32'(cli_rsp_err[2]), 0);
    chk("R7 ready low follows owner", 32'(mgr_rsp_ready), 0);
    cli_rsp_ready = 3'b100;
    #0.5;
    chk("R7 ready follows owner", 32'(mgr_rsp_ready), 32'b010);
    mgr_rsp_valid = '0;
    cli_rsp_ready = '0;
  endtask

  // R4 / R8: decode error response and hold
  task automatic t_decerr;
    @(negedge clk);
    cli_rsp_ready = 3'b000;
    drive_cli(1, 12'h200, 16'h0, 1'b0);
    #1;
    chk("R4 no manager valid", 32'(mgr_req_valid), 0);
    chk("R4 miss accepted", 32'(cli_req_ready[1]), 1);
    chk("R4 no response yet", 32'(cli_rsp_valid), 0);
    @(negedge clk);
    cli_req_valid = '0;
    #1;
    chk("R4 err resp to client 1 only", 32'(cli_rsp_valid), 32'b010);
    chk("R4 err flag", 32'(cli_rsp_err[1]), 1);
    chk("R4 err data zero", 32'(cli_rsp_rdata[DW +: DW]), 0);
    drive_cli(1, 12'h300, 16'h0, 1'b0);
    #0.5;
    chk("R8 new miss blocked", 32'(cli_req_ready[1]), 0);
    cli_req_valid = '0;
    @(negedge clk);
    #1;
    chk("R8 err held", 32'(cli_rsp_valid), 32'b010);
    chk("R8 err flag held", 32'(cli_rsp_err[1]), 1);
    cli_rsp_ready = 3'b010;
    @(negedge clk);
    #1;
    chk("R8 err cleared after ready", 32'(cli_rsp_valid), 0);
    cli_rsp_ready = '0;
  endtask

  // R4 / R7: error response and manager response in the same cycle
  task automatic t_concurrent;
    @(negedge clk);
    cli_rsp_ready = 3'b111;
    drive_cli(2, 12'h000, 16'h0, 1'b0);
    @(negedge clk);
    cli_req_valid = '0;
    mgr_rsp_valid = 3'b001;
    mgr_rsp_id    = 6'b00_00_00;
    mgr_rsp_rdata[0 +: DW] = 16'h1234;
    #1;
    chk("R7 both clients valid", 32'(cli_rsp_valid), 32'b101);
    chk("R7 client 0 data", 32'(cli_rsp_rdata[0 +: DW]), 32'h1234);
    chk("R7 client 0 not err", 32'(cli_rsp_err[0]), 0);
    chk("R4 client 2 err", 32'(cli_rsp_err[2]), 1);
    chk("R7 bank A ready", 32'(mgr_rsp_ready), 32'b001);
    @(negedge clk);
    mgr_rsp_valid = '0;
    #1;
    chk("R4 all drained", 32'(cli_rsp_valid), 0);
    cli_rsp_ready = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_rr();
    t_route();
    t_parallel();
    t_rsp_route();
    t_decerr();
    t_concurrent();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule